// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single counter channel tied to one external pin. Software picks one of three jobs for the pin. As an output it carries a pulse-width waveform set by a period and a high time. As an input it can serve as the count clock, so the channel counts events arriving on it. As an input it can also be measured: the number of count ticks that pass while the pin is high is stored when the pin goes low. In the output and measurement modes the count tick is chosen from three sources: every system clock cycle, or rising edges of one of two external clock inputs.

The channel is set up over a small register bus with a write strobe, a shared address and combinational read data. Every external input passes through a synchronizer and an edge detector before the logic sees it. One sticky status bit records period completions and finished measurements and drives the interrupt line. A second sticky bit flags a configuration that cannot produce a waveform. Writing a one to a status bit clears it.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe` and `irq` are low.
- R2: Register map on `bus_addr`: 0 control (bits [1:0] mode: 0 waveform output, 1 pin-clocked counting, 2 high-time measurement, 3 idle; bits [3:2] tick source: 0 or 3 system clock, 1 `ext_clk_a`, 2 `ext_clk_b`; bit 4 enable), 1 period, 2 high time, 3 status (bit 0 event, bit 1 error), 4 current count (read only). `bus_rdata` shows the addressed register in the same cycle.
- R3: In waveform mode with the channel enabled, `pin_oe` is high, the counter steps through 0 to period-1 on each tick, and `pin_out` is high while the count is below the high time. With system clock ticks, any run of period consecutive cycles holds exactly min(high time, period) high cycles.
- R4: In waveform and measurement modes the counter advances only on ticks from the selected source; edges on an unselected external clock input change nothing.
- R5: In pin-clocked mode the counter advances once per rising edge of `pin_in`, the tick source field is ignored, and the count returns to 0 on the edge that would reach the period.
- R6: In measurement mode, when `pin_in` falls the high-time register receives the number of ticks seen while the pin was high; `pin_oe` stays low.
- R7: Status bit 0 is set by every period wrap in waveform or pin-clocked mode and by every finished measurement; it stays set until cleared and drives `irq`.
- R8: Writing status with bit 0 or bit 1 at one clears that bit; a write with a bit at zero leaves it unchanged; a set in the same cycle wins over the clear.
- R9: While enabled, a zero period in waveform or pin-clocked mode, or a zero high time in waveform mode, sets status bit 1, holds the count at 0 and keeps `pin_out` low.
- R10: An edge on `pin_in` or an external clock input changes the count at the third rising clock edge after the input changes.
- R11: With the enable bit clear the count is held at 0 and `pin_out` and `pin_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| pin_in | input | 1 | Channel pin, input side |
| pin_out | output | 1 | Channel pin, output value |
| pin_oe | output | 1 | Channel pin, output enable |
| ext_clk_a | input | 1 | First external tick source |
| ext_clk_b | input | 1 | Second external tick source |
| irq | output | 1 | Event interrupt, mirrors status bit 0 |

## Verification
A register write takes effect at the clock edge that samples it and reads are combinational, so the bench reads half a cycle after placing an address. An input edge reaches the counter three rising edges after it is driven. The bench drives inputs and samples outputs on the falling edge, and it reads counts and captures several cycles after the last input change so that the synchronizer delay has passed. The waveform is checked by counting high samples over a whole number of periods, which gives an exact expected value independent of the counter's phase. The latency test for R10 samples the count at the second and third falling edges after a pin rise.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      MODE_WAVE    = 2'd0,
      MODE_PINCLK  = 2'd1,
      MODE_MEASURE = 2'd2,
      MODE_IDLE    = 2'd3
   } gpt_mode_e;

   typedef enum logic [1:0] {
      SRC_SYS  = 2'd0,
      SRC_EXTA = 2'd1,
      SRC_EXTB = 2'd2,
      SRC_SYS2 = 2'd3
   } gpt_src_e;

   typedef struct packed {
      logic      en;
      gpt_src_e  src;
      gpt_mode_e mode;
   } gpt_ctrl_t;

   localparam int CTRL_W = $bits(gpt_ctrl_t);

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_PERIOD = 3'd1;
   localparam logic [2:0] A_HIGH   = 3'd2;
   localparam logic [2:0] A_STATUS = 3'd3;
   localparam logic [2:0] A_COUNT  = 3'd4;

endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic prev
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign prev  = prev_q;
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [2:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          evt_set,
   input  logic          err_set,
   input  logic          cap_valid,
   input  logic [DW-1:0] cap_value,
   input  logic [DW-1:0] count,
   output gpt_ctrl_t     ctrl,
   output logic [DW-1:0] period,
   output logic [DW-1:0] high_time,
   output logic [1:0]    status
);
   logic wr_ctrl, wr_per, wr_high, wr_stat;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_per  = bus_wr && (bus_addr == A_PERIOD);
   assign wr_high = bus_wr && (bus_addr == A_HIGH);
   assign wr_stat = bus_wr && (bus_addr == A_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         period    <= '0;
         high_time <= '0;
         status    <= '0;
      end else begin
         if (wr_ctrl) ctrl <= gpt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_per)  period <= bus_wdata;
         // a finished measurement overrides a software write in the same cycle
         if (cap_valid)     high_time <= cap_value;
         else if (wr_high)  high_time <= bus_wdata;
         status[0] <= evt_set | (status[0] & ~(wr_stat & bus_wdata[0]));
         status[1] <= err_set | (status[1] & ~(wr_stat & bus_wdata[1]));
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl;
         A_PERIOD: bus_rdata = period;
         A_HIGH:   bus_rdata = high_time;
         A_STATUS: bus_rdata[1:0] = status;
         A_COUNT:  bus_rdata = count;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
   import gpt_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  gpt_ctrl_t     ctrl,
   input  logic [DW-1:0] period,
   input  logic [DW-1:0] high_time,
   input  logic [2:0]    lvl,
   input  logic [2:0]    prv,
   output logic [DW-1:0] count,
   output logic          pin_out,
   output logic          pin_oe,
   output logic          evt_set,
   output logic          err_set,
   output logic          cap_valid,
   output logic [DW-1:0] cap_value
);
   localparam logic [DW-1:0] CNT_MAX = '1;

   logic [2:0]    rise;
   logic          pin_fall;
   logic          tick, step, wrap, cfg_bad, busy_q;
   logic [DW-1:0] cnt_q;

   assign rise     = lvl & ~prv;
   assign pin_fall = ~lvl[0] & prv[0];

   always_comb begin
      case (ctrl.src)
         SRC_EXTA: tick = rise[1];
         SRC_EXTB: tick = rise[2];
         default:  tick = 1'b1;
      endcase
   end

   assign step = (ctrl.mode == MODE_PINCLK) ? rise[0] : tick;

   assign cfg_bad = ctrl.en &&
      (((ctrl.mode == MODE_WAVE) && ((period == '0) || (high_time == '0))) ||
       ((ctrl.mode == MODE_PINCLK) && (period == '0)));

   assign wrap = step && (cnt_q >= period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (!ctrl.en || ctrl.mode == MODE_IDLE) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (ctrl.mode == MODE_MEASURE) begin
         if (rise[0]) begin
            cnt_q  <= {{(DW-1){1'b0}}, tick};
            busy_q <= 1'b1;
         end else if (busy_q && pin_fall) begin
            busy_q <= 1'b0;
         end else if (busy_q && lvl[0] && tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         busy_q <= 1'b0;
         if (cfg_bad)    cnt_q <= '0;
         else if (wrap)  cnt_q <= '0;
         else if (step)  cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cap_valid = ctrl.en && (ctrl.mode == MODE_MEASURE) && busy_q && pin_fall;
   assign cap_value = cnt_q;
   assign err_set   = cfg_bad;
   assign evt_set   = cap_valid ||
      (ctrl.en && !cfg_bad && wrap &&
       ((ctrl.mode == MODE_WAVE) || (ctrl.mode == MODE_PINCLK)));

   assign pin_oe  = ctrl.en && (ctrl.mode == MODE_WAVE);
   assign pin_out = pin_oe && !cfg_bad && (cnt_q < high_time);
   assign count   = cnt_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
   import gpt_pkg::*;
#(
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [2:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          pin_oe,
   input  logic          ext_clk_a,
   input  logic          ext_clk_b,
   output logic          irq
);
   localparam int N_IN = 3;

   if (DW < CTRL_W) begin : g_bad_dw
      $error("DW must hold the control fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_IN-1:0] raw_in, lvl, prv;
   gpt_ctrl_t       ctrl;
   logic [DW-1:0]   period, high_time, cnt, cap_value;
   logic [1:0]      status;
   logic            evt_set, err_set, cap_valid;

   assign raw_in = {ext_clk_b, ext_clk_a, pin_in};

   for (genvar i = 0; i < N_IN; i++) begin : g_sync
      gpt_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_in[i]),
         .level (lvl[i]),
         .prev  (prv[i])
      );
   end

   gpt_regs #(.DW(DW)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_set   (evt_set),
      .err_set   (err_set),
      .cap_valid (cap_valid),
      .cap_value (cap_value),
      .count     (cnt),
      .ctrl      (ctrl),
      .period    (period),
      .high_time (high_time),
      .status    (status)
   );

   gpt_core #(.DW(DW)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .period    (period),
      .high_time (high_time),
      .lvl       (lvl),
      .prv       (prv),
      .count     (cnt),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .evt_set   (evt_set),
      .err_set   (err_set),
      .cap_valid (cap_valid),
      .cap_value (cap_value)
   );

   assign irq = status[0];
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk
   import gpt_pkg::*;
#(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [2:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          pin_out,
   input logic          pin_oe,
   input logic          irq,
   input gpt_ctrl_t     ctrl,
   input logic [DW-1:0] period,
   input logic [DW-1:0] high_time,
   input logic [DW-1:0] cnt,
   input logic [1:0]    status,
   input logic          cap_valid
);
   // R3: the pin is only driven high while the output side is enabled
   a_r3_drive_guard: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out |-> pin_oe);

   // R3: the count stays below an unchanged period in waveform mode
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && ctrl.mode == MODE_WAVE && period != '0 && cnt < period)
      |=> ($changed(period) || ctrl.mode != MODE_WAVE || cnt < period));

   // R9: an unusable waveform setting keeps the pin low
   a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 || high_time == '0) |-> !pin_out);

   // R9: a zero period in waveform mode raises the error flag
   a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && ctrl.mode == MODE_WAVE && period == '0) |=> status[1]);

   // R7: the event bit holds until a clearing write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && bus_addr == A_STATUS && bus_wdata[0])) |=> irq);

   // R6: a finished measurement stores the count and raises the event
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> (irq && high_time == $past(cnt)));
endmodule

bind gp_timer gp_timer_chk #(.DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .ctrl      (ctrl),
   .period    (period),
   .high_time (high_time),
   .cnt       (cnt),
   .status    (status),
   .cap_valid (cap_valid)
);

// File: tb/gp_timer_tb_top.sv
`timescale 1ns/1ps
module gp_timer_tb_top;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          pin_in = 1'b0;
   logic          pin_out, pin_oe;
   logic          ext_clk_a = 1'b0;
   logic          ext_clk_b = 1'b0;
   logic          irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   gp_timer #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .ext_clk_a(ext_clk_a),
      .ext_clk_b(ext_clk_b), .irq(irq)
   );

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; pin_in = 0; ext_clk_a = 0; ext_clk_b = 0; bus_wr = 0;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
   endtask

   task automatic wr(logic [2:0] a, int d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = DW'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic pulse_pin(int hi);
      pin_in = 1'b1; cycles(hi);
      pin_in = 1'b0; cycles(2);
   endtask

   task automatic pulse_ext(bit which_b, int n);
      for (int i = 0; i < n; i++) begin
         if (which_b) ext_clk_b = 1'b1; else ext_clk_a = 1'b1;
         cycles(2);
         ext_clk_a = 1'b0; ext_clk_b = 1'b0;
         cycles(2);
      end
   endtask

   task automatic count_high(int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pin_out) hi++;
      end
   endtask

   task automatic t_reset();
      int v;
      apply_reset();
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         check($sformatf("R1 reg %0d after reset", a), v, 0);
      end
      check("R1 pin_out after reset", int'(pin_out), 0);
      check("R1 pin_oe after reset", int'(pin_oe), 0);
      check("R1 irq after reset", int'(irq), 0);
   endtask

   task automatic t_wave(int p, int w);
      int v, hi;
      apply_reset();
      wr(3'd1, p); wr(3'd2, w);
      wr(3'd0, 'h10);
      rd(3'd0, v);
      check("R2 control readback", v, 'h10);
      cycles(4);
      count_high(3 * p, hi);
      check($sformatf("R3 high samples p=%0d w=%0d", p, w), hi, 3 * ((w < p) ? w : p));
      check("R3 pin_oe in waveform mode", int'(pin_oe), 1);
      check("R7 event after wraps", int'(irq), 1);
      rd(3'd4, v);
      check("R3 count below period", int'(v < p), 1);
      wr(3'd0, 'h00);
      cycles(2);
      rd(3'd4, v);
      check("R11 count held when disabled", v, 0);
      count_high(p + 2, hi);
      check("R11 pin_out low when disabled", hi, 0);
      check("R11 pin_oe low when disabled", int'(pin_oe), 0);
      wr(3'd3, 'h0);
      check("R8 zero write keeps event", int'(irq), 1);
      wr(3'd3, 'h1);
      rd(3'd3, v);
      check("R8 one write clears event", v, 0);
   endtask

   task automatic t_source();
      int v;
      apply_reset();
      wr(3'd1, 4); wr(3'd2, 1);
      wr(3'd0, 'h14);
      cycles(5);
      rd(3'd4, v);
      check("R4 no ticks without ext_clk_a edges", v, 0);
      pulse_ext(1'b1, 3);
      cycles(3);
      rd(3'd4, v);
      check("R4 ext_clk_b ignored while a selected", v, 0);
      pulse_ext(1'b0, 3);
      cycles(3);
      rd(3'd4, v);
      check("R4 three ext_clk_a ticks", v, 3);
      check("R3 pin low when count at high time", int'(pin_out), 0);
      wr(3'd0, 'h18);
      pulse_ext(1'b0, 1);
      cycles(3);
      rd(3'd4, v);
      check("R4 ext_clk_a ignored while b selected", v, 3);
      check("R4 no event before wrap", int'(irq), 0);
      pulse_ext(1'b1, 1);
      cycles(3);
      rd(3'd4, v);
      check("R4 ext_clk_b tick wraps count", v, 0);
      check("R7 event on wrap", int'(irq), 1);
   endtask

   task automatic t_pinclk();
      int v;
      apply_reset();
      wr(3'd1, 4);
      wr(3'd0, 'h11);
      cycles(5);
      rd(3'd4, v);
      check("R5 system clock ignored in pin-clocked mode", v, 0);
      pin_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd(3'd4, v);
      check("R10 count unchanged two edges after input", v, 0);
      @(negedge clk);
      rd(3'd4, v);
      check("R10 count changed at third edge", v, 1);
      pin_in = 1'b0; cycles(2);
      pulse_pin(2); pulse_pin(2);
      cycles(3);
      rd(3'd4, v);
      check("R5 three pin edges", v, 3);
      check("R5 no event before period", int'(irq), 0);
      pulse_pin(2);
      cycles(3);
      rd(3'd4, v);
      check("R5 count wraps at period", v, 0);
      check("R5 event at period", int'(irq), 1);
      check("R5 pin not driven", int'(pin_oe), 0);
   endtask

   task automatic t_measure();
      int v;
      apply_reset();
      wr(3'd0, 'h12);
      cycles(3);
      pulse_pin(7);
      cycles(4);
      rd(3'd2, v);
      check("R6 measured system clock high time", v, 7);
      check("R6 event after measurement", int'(irq), 1);
      check("R6 pin_oe low in measurement", int'(pin_oe), 0);
      wr(3'd3, 'h1);
      check("R8 event cleared", int'(irq), 0);
      wr(3'd0, 'h16);
      pin_in = 1'b1;
      cycles(3);
      pulse_ext(1'b0, 5);
      pulse_ext(1'b1, 2);
      cycles(2);
      pin_in = 1'b0;
      cycles(5);
      rd(3'd2, v);
      check("R6 measured ext_clk_a ticks", v, 5);
      check("R7 event after second measurement", int'(irq), 1);
   endtask

   task automatic t_error();
      int v, hi;
      apply_reset();
      wr(3'd2, 3);
      wr(3'd0, 'h10);
      cycles(3);
      rd(3'd3, v);
      check("R9 zero period sets error only", v, 2);
      count_high(10, hi);
      check("R9 pin low with zero period", hi, 0);
      rd(3'd4, v);
      check("R9 count held at zero", v, 0);
      wr(3'd0, 'h00);
      wr(3'd3, 'h2);
      rd(3'd3, v);
      check("R8 error bit cleared", v, 0);
      wr(3'd1, 5); wr(3'd2, 0);
      wr(3'd0, 'h10);
      cycles(3);
      rd(3'd3, v);
      check("R9 zero high time sets error", v, 2);
      count_high(10, hi);
      check("R9 pin low with zero high time", hi, 0);
   endtask

   initial begin
      t_reset();
      t_wave(8, 3);
      t_wave(5, 6);
      t_source();
      t_pinclk();
      t_measure();
      t_error();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule